// File: doc/BRIEF.md
# Paged Asynchronous Static RAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K bytes. The host hands it one request at a time over a valid/ready port: a single-byte write, a single-byte read, or a burst read of up to 16 bytes. The controller turns each request into correctly timed chip-select, write-strobe, output-strobe, address and data-bus activity. Every analog interval (access time, strobe width, bus release) is given in nanoseconds as a parameter and converted, rounded up, into whole clock cycles.

A burst read keeps the upper fourteen address bits frozen and walks the four lowest bits upward, so every byte of the burst comes from one 16-byte page of the memory. A burst that would run past the end of its page is cut short at the last byte of the page, and a flag tells the host so. Between requests the memory is parked in standby: both selects inactive, both strobes high and the data driver released.

The data bus is carried as three separate signals (value out, value in, drive enable), and the pad buffer lives outside this block.

Top module: `sram_pager_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the memory is in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high; `req_ready` is low from the next cycle until the memory access and its recovery are complete.
- R3: A write (`req_write`=1) selects the chip (`mem_ce1_n`=0, `mem_ce2`=1), holds `mem_oe_n` high and drives `wdata` on `mem_dq_out` with `mem_dq_oe`=1; `mem_we_n` stays low for at least 40 ns and at least 50 ns after the address became valid, address and data stay stable while it is low, and the memory then holds `wdata` at `addr`.
- R4: A single read (`req_write`=0, `req_burst`=0) selects the chip with `mem_oe_n`=0 and `mem_we_n`=1, keeps the address unchanged for at least 70 ns, then returns the byte on `rdata` with a one-cycle `rvalid` pulse.
- R5: A burst read (`req_burst`=1) keeps `mem_addr[17:4]` equal to `addr[17:4]` and presents `mem_addr[3:0]` = `addr[3:0]`, `addr[3:0]`+1, ... in order, each for at least 70 ns, returning one `rvalid` pulse per byte in that order.
- R6: A burst returns min(L, 16 − `addr[3:0]`) bytes, where L is `req_len` and a value of 0 counts as 1.
- R7: `burst_truncated` is set on acceptance of a burst whose `req_len` exceeds 16 − `addr[3:0]`, cleared on acceptance of any other request, and held unchanged otherwise.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R9: After a read ends (`mem_oe_n` rises and the chip is deselected), `mem_dq_oe` does not rise for at least 20 ns.
- R10: A single read returns exactly one byte whatever the value of `req_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write one byte, 0 = read |
| req_burst | input | 1 | For reads: 1 = page burst, 0 = single byte |
| req_len | input | 5 | Burst length in bytes, 1 to 16 (0 treated as 1) |
| addr | input | 18 | Byte address of the request |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte returned by a read |
| rvalid | output | 1 | One-cycle pulse per returned byte |
| burst_truncated | output | 1 | Last accepted burst was shortened at the page end |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_out | output | 8 | Value to place on the memory data bus |
| mem_dq_in | input | 8 | Value seen on the memory data bus |
| mem_dq_oe | output | 1 | Drive enable for the memory data bus |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |

## Verification
The hardest situation to reach is a write issued straight after a burst read, where the bus release interval is the only thing keeping the controller's driver off a bus the memory may still hold. The stimulus runs a truncated burst and then immediately queues a write, while the bench's memory model stamps the time of the output strobe's rise and measures the gap to the driver's next rise. The same model returns a poison byte whenever the address, select or output strobe changed less than 70 ns before it is sampled, so any shortened access shows up as wrong data in the burst sequence.

// File: rtl/sram_pager_pkg.sv
package sram_pager_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_ACC,
    ST_RD_REL
  } ctrl_state_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bytes left in the page starting from word index lo
  function automatic int unsigned page_room(int unsigned lo, int unsigned page_words);
    return page_words - lo;
  endfunction

  // number of bytes a read request actually fetches
  function automatic int unsigned grant_words(logic burst, int unsigned len,
                                              int unsigned lo, int unsigned page_words);
    int unsigned want;
    int unsigned room;
    if (!burst) return 1;
    want = (len == 0) ? 1 : len;
    room = page_room(lo, page_words);
    return (want > room) ? room : want;
  endfunction

  // a burst is cut short when it asks for more than the page holds
  function automatic logic is_truncated(logic burst, int unsigned len,
                                        int unsigned lo, int unsigned page_words);
    return burst && (len > page_room(lo, page_words));
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_page_walker.sv
module sram_page_walker #(
  parameter int unsigned AW = 18,
  parameter int unsigned PB = 4,
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_words,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic          last_word
);
  logic [AW-PB-1:0] page_q;
  logic [PB-1:0]    word_q;
  logic [LW-1:0]    left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      word_q <= '0;
      left_q <= '0;
    end else if (start) begin
      page_q <= start_addr[AW-1:PB];
      word_q <= start_addr[PB-1:0];
      left_q <= start_words;
    end else if (step) begin
      word_q <= word_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  assign cur_addr  = {page_q, word_q};
  assign last_word = (left_q <= LW'(1));
endmodule

// File: rtl/sram_pager_ctrl.sv
module sram_pager_ctrl
  import sram_pager_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS       = 4,
  parameter int unsigned ADDR_W              = 18,
  parameter int unsigned DATA_W              = 8,
  parameter int unsigned PAGE_BITS           = 4,
  parameter int unsigned T_ACCESS_NS         = 70,
  parameter int unsigned T_CYCLE_NS          = 70,
  parameter int unsigned T_WE_PULSE_NS       = 40,
  parameter int unsigned T_ADDR_TO_WE_END_NS = 50,
  parameter int unsigned T_DATA_OVERLAP_NS   = 40,
  parameter int unsigned T_RELEASE_NS        = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_burst,
  input  logic [PAGE_BITS:0]   req_len,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid,
  output logic                 burst_truncated,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_dq_out,
  input  logic [DATA_W-1:0]    mem_dq_in,
  output logic                 mem_dq_oe,
  output logic                 mem_ce1_n,
  output logic                 mem_ce2,
  output logic                 mem_we_n,
  output logic                 mem_oe_n
);
  localparam int unsigned PAGE_WORDS = 1 << PAGE_BITS;
  localparam int unsigned LEN_W      = PAGE_BITS + 1;
  localparam int unsigned ACC_CYC    = max2(1, ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS));
  localparam int unsigned WP_CYC     = max2(1, max2(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                          max2(ns_to_cycles(T_ADDR_TO_WE_END_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_DATA_OVERLAP_NS, CLK_PERIOD_NS))));
  localparam int unsigned CYC_CYC    = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC   = (CYC_CYC > WP_CYC) ? (CYC_CYC - WP_CYC) : 1;
  localparam int unsigned TURN_CYC   = max2(1, ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS));
  localparam int unsigned TMR_MAX    = max2(max2(ACC_CYC, WP_CYC), max2(HOLD_CYC, TURN_CYC));
  localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);

  ctrl_state_t state_q;

  logic              ce1_n_q, ce2_q, we_n_q, oe_n_q, dq_oe_q;
  logic [DATA_W-1:0] dq_out_q, rdata_q;
  logic              rvalid_q, trunc_q;

  // named internal events, also watched by the checker
  logic              accept;
  logic              capture;
  logic              tmr_expired;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              walk_last;
  logic [LEN_W-1:0]  words_granted;
  logic              req_trunc;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_RD_ACC) && tmr_expired;

  assign words_granted = req_write ? LEN_W'(1)
                       : LEN_W'(grant_words(req_burst, 32'(req_len),
                                            32'(addr[PAGE_BITS-1:0]), PAGE_WORDS));
  assign req_trunc = !req_write &&
                     is_truncated(req_burst, 32'(req_len), 32'(addr[PAGE_BITS-1:0]), PAGE_WORDS);

  sram_interval_timer #(.CW(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_page_walker #(.AW(ADDR_W), .PB(PAGE_BITS), .LW(LEN_W)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_addr  (addr),
    .start_words (words_granted),
    .step        (capture && !walk_last),
    .cur_addr    (mem_addr),
    .last_word   (walk_last)
  );

  // interval to count in the state being entered
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = req_write ? TMR_W'(WP_CYC - 1) : TMR_W'(ACC_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HOLD_CYC - 1);
      end
      ST_RD_ACC: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = walk_last ? TMR_W'(TURN_CYC - 1) : TMR_W'(ACC_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ce1_n_q  <= 1'b1;
      ce2_q    <= 1'b0;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      dq_out_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      trunc_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          ce1_n_q <= 1'b0;
          ce2_q   <= 1'b1;
          trunc_q <= req_trunc;
          if (req_write) begin
            we_n_q   <= 1'b0;
            dq_oe_q  <= 1'b1;
            dq_out_q <= wdata;
            state_q  <= ST_WR_PULSE;
          end else begin
            oe_n_q   <= 1'b0;
            state_q  <= ST_RD_ACC;
          end
        end
        ST_WR_PULSE: if (tmr_expired) begin
          we_n_q  <= 1'b1;
          state_q <= ST_WR_HOLD;
        end
        ST_WR_HOLD: if (tmr_expired) begin
          ce1_n_q <= 1'b1;
          ce2_q   <= 1'b0;
          dq_oe_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_RD_ACC: if (tmr_expired) begin
          rdata_q  <= mem_dq_in;
          rvalid_q <= 1'b1;
          if (walk_last) begin
            oe_n_q  <= 1'b1;
            ce1_n_q <= 1'b1;
            ce2_q   <= 1'b0;
            state_q <= ST_RD_REL;
          end
        end
        ST_RD_REL: if (tmr_expired) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdata           = rdata_q;
  assign rvalid          = rvalid_q;
  assign burst_truncated = trunc_q;
  assign mem_dq_out      = dq_out_q;
  assign mem_dq_oe       = dq_oe_q;
  assign mem_ce1_n       = ce1_n_q;
  assign mem_ce2         = ce2_q;
  assign mem_we_n        = we_n_q;
  assign mem_oe_n        = oe_n_q;
endmodule

// File: rtl/sram_pager_chk.sv
module sram_pager_chk #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_BITS = 4,
  parameter int unsigned TURN_CYC  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              accept,
  input logic              capture
);
  localparam int unsigned GW = $clog2(TURN_CYC + 2);

  // cycles since the output strobe was last seen low, saturating
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= GW'(TURN_CYC);
    else if (!mem_oe_n)             gap_q <= '0;
    else if (gap_q < GW'(TURN_CYC)) gap_q <= gap_q + 1'b1;
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3
  write_strobe_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe && mem_oe_n));

  // R3
  write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R4
  capture_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rvalid);

  // R5
  page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |->
      (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS])));

  // R8
  no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R9
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap_q >= GW'(TURN_CYC)));
endmodule

bind sram_pager_ctrl sram_pager_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PAGE_BITS (PAGE_BITS),
  .TURN_CYC  (TURN_CYC)
) u_chk (.*);

// File: tb/sram_pager_ctrl_tb.sv
`timescale 1ns/1ps
module sram_pager_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [4:0]  req_len = '0;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        burst_truncated;
  logic [17:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;
  logic        mem_dq_oe, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  sram_pager_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_len(req_len), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .burst_truncated(burst_truncated),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- sparse memory model ----------------
  logic [7:0] store [int];

  function automatic logic [7:0] ref_byte(input logic [17:0] a);
    logic [7:0] mix;
    if (store.exists(int'(a))) return store[int'(a)];
    mix = a[7:0] ^ {a[15:10], a[17:16]} ^ 8'h3B;
    return mix + {4'b0, a[11:8]};
  endfunction

  realtime t_addr = 0.0, t_sel = 0.0, t_oefall = 0.0, t_wefall = 0.0, t_dq = 0.0;
  realtime t_release = -1000.0;

  always @(mem_addr)              t_addr = $realtime;
  always @(mem_ce1_n or mem_ce2)  t_sel = $realtime;
  always @(mem_dq_out)            t_dq = $realtime;
  always @(negedge mem_oe_n)      t_oefall = $realtime;
  always @(posedge mem_oe_n)      t_release = $realtime;
  always @(negedge mem_we_n)      t_wefall = $realtime;

  // data valid only once address, select and output strobe are 70 ns old
  always @(negedge clk) begin
    realtime t0;
    if (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n) begin
      t0 = t_addr;
      if (t_sel > t0)    t0 = t_sel;
      if (t_oefall > t0) t0 = t_oefall;
      mem_dq_in = ($realtime - t0 >= 70.0) ? ref_byte(mem_addr) : 8'hEE;
    end else begin
      mem_dq_in = 8'h00;
    end
  end

  // end of write: check widths, then commit
  always @(posedge mem_we_n) begin
    if (rst_n === 1'b1 && mem_ce1_n === 1'b0 && mem_ce2 === 1'b1) begin
      chk($realtime - t_wefall >= 40.0, "R3", "write pulse ns", int'($realtime - t_wefall), 40);
      chk($realtime - t_addr >= 50.0, "R3", "addr to write end ns", int'($realtime - t_addr), 50);
      chk($realtime - t_dq >= 40.0, "R3", "data overlap ns", int'($realtime - t_dq), 40);
      chk(mem_dq_oe === 1'b1, "R3", "driving at write end", int'(mem_dq_oe), 1);
      store[int'(mem_addr)] = mem_dq_out;
    end
  end

  always @(posedge mem_dq_oe) begin
    if (rst_n === 1'b1)
      chk($realtime - t_release >= 20.0, "R9", "release gap ns", int'($realtime - t_release), 20);
  end

  always @(negedge clk) begin
    if (rst_n && mem_dq_oe && !mem_oe_n)
      chk(1'b0, "R8", "drive during read", 1, 0);
  end

  logic [7:0] got [$];
  always @(negedge clk) if (rst_n && rvalid) got.push_back(rdata);

  // ---------------- request driver ----------------
  task automatic issue(input bit wr, input bit bu, input int len,
                       input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_burst = bu;
    req_len = 5'(len); addr = a; wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low after accept", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    chk(req_ready, "R2", "ready back when done", int'(req_ready), 1);
  endtask

  task automatic t_reset_state();
    chk(mem_ce1_n === 1'b1 && mem_ce2 === 1'b0, "R1", "selects idle", {mem_ce1_n, mem_ce2}, 2);
    chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1", "strobes idle", {mem_we_n, mem_oe_n}, 3);
    chk(mem_dq_oe === 1'b0, "R1", "driver off", int'(mem_dq_oe), 0);
    chk(req_ready === 1'b1 && rvalid === 1'b0, "R1", "ready/rvalid", {req_ready, rvalid}, 2);
  endtask

  task automatic t_write(input logic [17:0] a, input logic [7:0] d);
    issue(1'b1, 1'b0, 1, a, d);
    chk(ref_byte(a) == d, "R3", "stored byte", int'(ref_byte(a)), int'(d));
    chk(burst_truncated == 1'b0, "R7", "flag after write", int'(burst_truncated), 0);
  endtask

  task automatic t_read(input bit bu, input int len, input logic [17:0] a, input bit exp_trunc,
                        input string req);
    int n;
    int room;
    room = 16 - int'(a[3:0]);
    n = !bu ? 1 : (len == 0 ? 1 : (len > room ? room : len));
    got.delete();
    issue(1'b0, bu, len, a, 8'h00);
    @(negedge clk);
    chk(got.size() == n, req, "byte count", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++) begin
      logic [17:0] ea;
      ea = {a[17:4], 4'(a[3:0] + 4'(i))};
      chk(got[i] == ref_byte(ea), req, "read byte", int'(got[i]), int'(ref_byte(ea)));
    end
    chk(burst_truncated == exp_trunc, "R7", "truncated flag", int'(burst_truncated), int'(exp_trunc));
  endtask

  task automatic t_standby_between();
    chk(mem_ce1_n === 1'b1 && mem_ce2 === 1'b0 && mem_dq_oe === 1'b0, "R1",
        "standby between requests", {mem_ce1_n, mem_ce2, mem_dq_oe}, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();                           // R1
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();                           // R1
    t_write(18'h00010, 8'hA5);                 // R3
    t_read(1'b0, 1, 18'h00010, 1'b0, "R4");    // R4
    t_write(18'h3FFFF, 8'h5A);                 // R3
    t_read(1'b0, 1, 18'h3FFFF, 1'b0, "R4");
    t_standby_between();                       // R1
    t_read(1'b0, 9, 18'h01234, 1'b0, "R10");   // R10 single read ignores length
    t_read(1'b1, 16, 18'h12340, 1'b0, "R5");   // R5 full page
    t_read(1'b1, 4, 18'h2ABC5, 1'b0, "R5");    // R5 mid page
    t_read(1'b1, 8, 18'h1000D, 1'b1, "R6");    // R6 cut at page end, R7 set
    repeat (3) @(negedge clk);
    chk(burst_truncated == 1'b1, "R7", "flag holds", int'(burst_truncated), 1);
    t_write(18'h1000F, 8'hC3);                 // R9 write right after read, R7 cleared
    t_read(1'b1, 0, 18'h1000F, 1'b0, "R6");    // R6 length zero -> one byte
    t_read(1'b1, 16, 18'h0003F, 1'b1, "R6");   // R6 last word of page
    t_write(18'h05555, 8'h3C);
    t_read(1'b1, 16, 18'h05550, 1'b0, "R5");   // R5 burst covering written byte
    t_write(18'h05550, 8'h81);                 // R9
    t_standby_between();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule